// File: doc/BRIEF.md
# Repeating Block-Transfer DMA Channel

This block is one DMA channel that copies memory to memory in a repeating block mode. Software programs a source start address, a destination start address, a transfer count and an address window, then enables the channel. Each trigger moves a whole block of `COUNT` items. A trigger is either a pulse on `trig_i` or a write to the software-request bit. Each item is one read from the source pointer, followed by one write of the same data to the destination pointer. Both bus phases wait for a grant.

When the last item of a block is written, the channel signals completion. It reloads its count, and it reloads each address pointer whose reload bit is set. It then stays armed for the next trigger, with no reprogramming needed. A trigger that arrives while a block is running is remembered and starts the next block as soon as the current one ends. The channel stops only when software clears its enable bit or an access falls outside the programmed window.

Top module: `dma_seq_top`

## Requirements
- R1: Triggers are accepted only when the mode field CTRL[2:1] equals 2'b11. With any other mode value, a trigger produces no bus request.
- R2: A `trig_i` pulse, or a CTRL write with bit 10 set, starts a block of COUNT transfers. This needs CTRL[0] (enable) set and COUNT (register 3) not zero.
- R3: Each transfer first requests a read (`mem_we_o`=0, address = source pointer). It holds that request and address until `mem_gnt_i`, then captures `mem_rdata_i`. It next requests a write (`mem_we_o`=1, address = destination pointer, data = the captured value) and holds that until grant.
- R4: After each transfer, a pointer whose increment bit is set advances by 1 << CTRL[9:8] bytes: 0 gives 1, 1 gives 2, 2 gives 4. The source increment bit is CTRL[3] and the destination increment bit is CTRL[4]. A pointer whose increment bit is clear stays fixed.
- R5: After the last transfer, the count is restored. The source pointer returns to register 1 if CTRL[5] is set, and the destination pointer returns to register 2 if CTRL[6] is set. Otherwise a pointer continues from where it stopped. Writing register 1 or 2 while the channel is idle also loads the pointer.
- R6: After a block ends, the channel stays armed, and a later trigger runs another block without any reprogramming.
- R7: A trigger that arrives during a block is held. The next block starts right after the reload, with no further trigger.
- R8: HALF (`half_o`) sets when the remaining count becomes floor(COUNT/2). DONE (`done_o`) sets when a block ends. `irq_o` is high while DONE is set and CTRL[7] is set.
- R9: A write to register 6 clears DONE, HALF and ERR for each 1 in bits 0, 1 and 2 respectively. A 0 in a bit leaves that flag unchanged.
- R10: Before each transfer, the source and destination pointers must both satisfy LOW (reg 4) <= addr < HIGH (reg 5). If either fails, no request is issued, ERR (`err_o`) sets, and the enable bit clears.
- R11: Clearing the enable bit drops any request in progress, returns the channel to idle and discards a held trigger. While the channel is disabled, triggers are ignored.
- R12: After reset, all registers and flags are zero and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 CTRL, 1 SRC, 2 DST, 3 COUNT, 4 LOW, 5 HIGH, 6 STATUS) |
| cfg_wdata | input | AW | Register write data |
| trig_i | input | 1 | Hardware trigger pulse |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Grant that completes the current phase |
| mem_rdata_i | input | DW | Read data, valid with grant in a read phase |
| chan_en_o | output | 1 | Current channel enable bit |
| done_o | output | 1 | Block complete flag |
| half_o | output | 1 | Half-way flag |
| err_o | output | 1 | Window violation flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The main function is driven with several pointer patterns: both pointers incrementing by words, a byte-stepping source into a fixed destination, and a destination that is not reloaded across two blocks. Together these separate the step size, the fixed-pointer case and the reload choice. Grant latency is varied between zero and several cycles, which shows that each phase holds its address until grant. It also places the HALF flag between transfers. A second trigger given mid-block checks that a held trigger produces exactly one more block. Window addresses at the lower bound and at the exclusive upper bound show where the abort happens.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHK  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_st_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_SRC  = 3'd1;
    localparam logic [2:0] RA_DST  = 3'd2;
    localparam logic [2:0] RA_CNT  = 3'd3;
    localparam logic [2:0] RA_LOW  = 3'd4;
    localparam logic [2:0] RA_HIGH = 3'd5;
    localparam logic [2:0] RA_STAT = 3'd6;

    localparam logic [1:0] MODE_RPT_CONT = 2'b11;

    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_SINC  = 3;
    localparam int CB_DINC  = 4;
    localparam int CB_RSRC  = 5;
    localparam int CB_RDST  = 6;
    localparam int CB_IRQEN = 7;
    localparam int CB_SIZE  = 8;
    localparam int CB_SWREQ = 10;

    localparam int SB_DONE = 0;
    localparam int SB_HALF = 1;
    localparam int SB_ERR  = 2;

endpackage

// File: rtl/dma_seq_win_chk.sv
module dma_seq_win_chk #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] low_i,
    input  logic [AW-1:0] high_i,
    output logic          ok_o
);
    logic ge_low;
    logic lt_high;

    always_comb begin
        ge_low  = (addr_i >= low_i);
        lt_high = (addr_i < high_i);
        ok_o    = ge_low && lt_high;
    end

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [2:0]    cfg_addr_i,
    input  logic [AW-1:0] cfg_wdata_i,
    input  logic          trig_i,
    input  logic          set_done_i,
    input  logic          set_half_i,
    input  logic          set_err_i,
    output logic          en_o,
    output logic          trig_o,
    output logic          rearm_ok_o,
    output logic          src_inc_o,
    output logic          dst_inc_o,
    output logic          rld_src_o,
    output logic          rld_dst_o,
    output logic [1:0]    size_o,
    output logic [AW-1:0] src_cfg_o,
    output logic [AW-1:0] dst_cfg_o,
    output logic [CW-1:0] cnt_cfg_o,
    output logic [AW-1:0] low_o,
    output logic [AW-1:0] high_o,
    output logic          ld_src_o,
    output logic          ld_dst_o,
    output logic [AW-1:0] ld_val_o,
    output logic          done_o,
    output logic          half_o,
    output logic          err_o,
    output logic          irq_o
);
    typedef struct packed {
        logic          en;
        logic [1:0]    mode;
        logic          sinc;
        logic          dinc;
        logic          rsrc;
        logic          rdst;
        logic          irqen;
        logic [1:0]    size;
        logic          swt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [AW-1:0] low;
        logic [AW-1:0] high;
        logic          done;
        logic          half;
        logic          err;
    } reg_s;

    reg_s q, d;

    always_comb begin
        d     = q;
        d.swt = 1'b0;
        if (cfg_we_i) begin
            case (cfg_addr_i)
                RA_CTRL: begin
                    d.en    = cfg_wdata_i[CB_EN];
                    d.mode  = cfg_wdata_i[CB_MODE +: 2];
                    d.sinc  = cfg_wdata_i[CB_SINC];
                    d.dinc  = cfg_wdata_i[CB_DINC];
                    d.rsrc  = cfg_wdata_i[CB_RSRC];
                    d.rdst  = cfg_wdata_i[CB_RDST];
                    d.irqen = cfg_wdata_i[CB_IRQEN];
                    d.size  = cfg_wdata_i[CB_SIZE +: 2];
                    d.swt   = cfg_wdata_i[CB_SWREQ];
                end
                RA_SRC:  d.src  = cfg_wdata_i;
                RA_DST:  d.dst  = cfg_wdata_i;
                RA_CNT:  d.cnt  = cfg_wdata_i[CW-1:0];
                RA_LOW:  d.low  = cfg_wdata_i;
                RA_HIGH: d.high = cfg_wdata_i;
                RA_STAT: begin
                    d.done = q.done & ~cfg_wdata_i[SB_DONE];
                    d.half = q.half & ~cfg_wdata_i[SB_HALF];
                    d.err  = q.err  & ~cfg_wdata_i[SB_ERR];
                end
                default: ;
            endcase
        end
        if (set_done_i) d.done = 1'b1;
        if (set_half_i) d.half = 1'b1;
        if (set_err_i) begin
            d.err = 1'b1;
            d.en  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rearm_ok_o = q.en && (q.mode == MODE_RPT_CONT) && (q.cnt != '0);
        trig_o     = (trig_i || q.swt) && rearm_ok_o;
        en_o       = q.en;
        src_inc_o  = q.sinc;
        dst_inc_o  = q.dinc;
        rld_src_o  = q.rsrc;
        rld_dst_o  = q.rdst;
        size_o     = q.size;
        src_cfg_o  = q.src;
        dst_cfg_o  = q.dst;
        cnt_cfg_o  = q.cnt;
        low_o      = q.low;
        high_o     = q.high;
        ld_src_o   = cfg_we_i && (cfg_addr_i == RA_SRC);
        ld_dst_o   = cfg_we_i && (cfg_addr_i == RA_DST);
        ld_val_o   = cfg_wdata_i;
        done_o     = q.done;
        half_o     = q.half;
        err_o      = q.err;
        irq_o      = q.done && q.irqen;
    end

    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        set_err_i |=> (!q.en && q.err)); // R10

    AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_addr_i == RA_STAT && cfg_wdata_i[SB_DONE] && !set_done_i) |=> !q.done); // R9

endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          trig_i,
    input  logic          rearm_ok_i,
    input  logic          src_inc_i,
    input  logic          dst_inc_i,
    input  logic          rld_src_i,
    input  logic          rld_dst_i,
    input  logic [1:0]    size_i,
    input  logic [AW-1:0] src_cfg_i,
    input  logic [AW-1:0] dst_cfg_i,
    input  logic [CW-1:0] cnt_cfg_i,
    input  logic [AW-1:0] low_i,
    input  logic [AW-1:0] high_i,
    input  logic          ld_src_i,
    input  logic          ld_dst_i,
    input  logic [AW-1:0] ld_val_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_gnt_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          set_done_o,
    output logic          set_half_o,
    output logic          set_err_o
);
    localparam int NPTR = 2;
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          pend;
    } eng_s;

    eng_s q, d;

    logic [AW-1:0] chk_addr [NPTR];
    logic [NPTR-1:0] win_ok;
    logic [AW-1:0] step;
    logic [AW-1:0] src_nx;
    logic [AW-1:0] dst_nx;
    logic [CW-1:0] cnt_dec;

    always_comb begin
        chk_addr[0] = q.src;
        chk_addr[1] = q.dst;
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_win
        dma_seq_win_chk #(.AW(AW)) u_chk (
            .addr_i (chk_addr[g]),
            .low_i  (low_i),
            .high_i (high_i),
            .ok_o   (win_ok[g])
        );
    end

    always_comb begin
        step    = ONE << size_i;
        src_nx  = q.src + (src_inc_i ? step : '0);
        dst_nx  = q.dst + (dst_inc_i ? step : '0);
        cnt_dec = q.cnt - 1'b1;
    end

    always_comb begin
        d          = q;
        set_done_o = 1'b0;
        set_half_o = 1'b0;
        set_err_o  = 1'b0;

        if (q.st != ST_IDLE && trig_i) d.pend = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    d.cnt = cnt_cfg_i;
                    d.st  = ST_CHK;
                end
            end
            ST_CHK: begin
                if (&win_ok) begin
                    d.st = ST_RD;
                end else begin
                    set_err_o = 1'b1;
                    d.st      = ST_IDLE;
                    d.pend    = 1'b0;
                end
            end
            ST_RD: begin
                if (mem_gnt_i) begin
                    d.data = mem_rdata_i;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_gnt_i) begin
                    d.src = src_nx;
                    d.dst = dst_nx;
                    d.cnt = cnt_dec;
                    if (cnt_dec == (cnt_cfg_i >> 1)) set_half_o = 1'b1;
                    if (cnt_dec == '0) begin
                        set_done_o = 1'b1;
                        d.cnt      = cnt_cfg_i;
                        if (rld_src_i) d.src = src_cfg_i;
                        if (rld_dst_i) d.dst = dst_cfg_i;
                        d.pend     = 1'b0;
                        d.st       = ((q.pend || trig_i) && rearm_ok_i) ? ST_CHK : ST_IDLE;
                    end else begin
                        d.st = ST_CHK;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (q.st == ST_IDLE) begin
            if (ld_src_i) d.src = ld_val_i;
            if (ld_dst_i) d.dst = ld_val_i;
        end

        if (!en_i) begin
            d.st   = ST_IDLE;
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req_o   = ((q.st == ST_RD) || (q.st == ST_WR)) && en_i;
        mem_we_o    = (q.st == ST_WR);
        mem_addr_o  = (q.st == ST_WR) ? q.dst : q.src;
        mem_wdata_o = q.data;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=>
            ((mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)) || !en_i)); // R3

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_gnt_i)); // R3

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.cnt != '0)); // R5

    AST_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.pend); // R7

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          trig_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_gnt_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          chan_en_o,
    output logic          done_o,
    output logic          half_o,
    output logic          err_o,
    output logic          irq_o
);
    logic          en, trig, rearm_ok;
    logic          src_inc, dst_inc, rld_src, rld_dst;
    logic [1:0]    size;
    logic [AW-1:0] src_cfg, dst_cfg, low, high, ld_val;
    logic [CW-1:0] cnt_cfg;
    logic          ld_src, ld_dst;
    logic          set_done, set_half, set_err;

    dma_seq_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .trig_i      (trig_i),
        .set_done_i  (set_done),
        .set_half_i  (set_half),
        .set_err_i   (set_err),
        .en_o        (en),
        .trig_o      (trig),
        .rearm_ok_o  (rearm_ok),
        .src_inc_o   (src_inc),
        .dst_inc_o   (dst_inc),
        .rld_src_o   (rld_src),
        .rld_dst_o   (rld_dst),
        .size_o      (size),
        .src_cfg_o   (src_cfg),
        .dst_cfg_o   (dst_cfg),
        .cnt_cfg_o   (cnt_cfg),
        .low_o       (low),
        .high_o      (high),
        .ld_src_o    (ld_src),
        .ld_dst_o    (ld_dst),
        .ld_val_o    (ld_val),
        .done_o      (done_o),
        .half_o      (half_o),
        .err_o       (err_o),
        .irq_o       (irq_o)
    );

    dma_seq_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .trig_i      (trig),
        .rearm_ok_i  (rearm_ok),
        .src_inc_i   (src_inc),
        .dst_inc_i   (dst_inc),
        .rld_src_i   (rld_src),
        .rld_dst_i   (rld_dst),
        .size_i      (size),
        .src_cfg_i   (src_cfg),
        .dst_cfg_i   (dst_cfg),
        .cnt_cfg_i   (cnt_cfg),
        .low_i       (low),
        .high_i      (high),
        .ld_src_i    (ld_src),
        .ld_dst_i    (ld_dst),
        .ld_val_i    (ld_val),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_gnt_i   (mem_gnt_i),
        .mem_rdata_i (mem_rdata_i),
        .set_done_o  (set_done),
        .set_half_o  (set_half),
        .set_err_o   (set_err)
    );

    assign chan_en_o = en;

endmodule

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
module dma_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trig = 1'b0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        chan_en, done, half, err, irq;

    int total = 0;
    int bad = 0;
    int wait_n = 0;
    int wcnt = 0;
    int nw = 0;
    int nreq = 0;
    logic log_clr = 1'b0;
    logic [31:0] wa [64];
    logic [31:0] wd [64];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0};
    endfunction

    assign mem_gnt   = mem_req && (wcnt >= wait_n);
    assign mem_rdata = pat(mem_addr);

    always @(posedge clk) begin
        if (mem_req && !mem_gnt) wcnt <= wcnt + 1;
        else                     wcnt <= 0;
        if (log_clr) begin
            nw   <= 0;
            nreq <= 0;
        end else begin
            if (mem_req) nreq <= nreq + 1;
            if (mem_req && mem_we && mem_gnt) begin
                if (nw < 64) begin
                    wa[nw] <= mem_addr;
                    wd[nw] <= mem_wdata;
                end
                nw <= nw + 1;
            end
        end
    end

    dma_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig_i(trig), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .chan_en_o(chan_en),
        .done_o(done), .half_o(half), .err_o(err), .irq_o(irq)
    );

    function automatic logic [31:0] mk(input bit en, input logic [1:0] mode,
        input bit si, input bit di, input bit rs, input bit rd, input bit ie,
        input logic [1:0] sz, input bit sw);
        logic [31:0] v;
        v = '0;
        v[0] = en; v[2:1] = mode; v[3] = si; v[4] = di;
        v[5] = rs; v[6] = rd; v[7] = ie; v[9:8] = sz; v[10] = sw;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all;
        wr(3'd6, 32'h7);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_nw(input int n);
        for (int i = 0; i < 3000 && nw < n; i++) @(negedge clk);
    endtask

    task automatic chk_blk(input string tag, input int first, input int n,
        input logic [31:0] s0, input logic [31:0] ss, input logic [31:0] d0, input logic [31:0] ds);
        for (int i = 0; i < n; i++) begin
            chk(wa[first+i] == d0 + ss * 0 + ds * i, tag, wa[first+i], d0 + ds * i);
            chk(wd[first+i] == pat(s0 + ss * i), tag, wd[first+i], pat(s0 + ss * i));
        end
    endtask

    task automatic t_reset;
        chk(!mem_req && !done && !half && !err && !irq && !chan_en, "R12 reset outputs",
            {26'h0, mem_req, done, half, err, irq, chan_en}, 32'h0);
    endtask

    task automatic t_basic;
        wait_n = 1;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1000);
        wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 32'd4);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        chk(!done && !half && !irq, "R9 flags clear", {29'h0, done, half, irq}, 32'h0);
        pulse;
        wait_nw(4); idle(6);
        chk(nw == 4, "R2 block length", nw, 4);
        chk_blk("R3 R4 word increment", 0, 4, 32'h100, 4, 32'h200, 4);
        chk(done && half && irq, "R8 done half irq", {29'h0, done, half, irq}, 32'h7);
    endtask

    task automatic t_half;
        wait_n = 3;
        clear_all;
        pulse;
        wait_nw(2);
        chk(half && !done, "R8 half at midpoint", {30'h0, half, done}, 32'h2);
        wait_nw(4); idle(10);
        chk(done, "R8 done at end", done, 1);
        chk_blk("R5 R6 rearmed reload", 0, 4, 32'h100, 4, 32'h200, 4);
    endtask

    task automatic t_noreload;
        wait_n = 0;
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 0, 1, 2'd2, 0));
        clear_all;
        pulse; wait_nw(4); idle(4);
        pulse; wait_nw(8); idle(6);
        chk(nw == 8, "R6 two blocks", nw, 8);
        chk_blk("R5 dst continues", 4, 4, 32'h100, 4, 32'h210, 4);
    endtask

    task automatic t_bytefixed;
        wait_n = 0;
        wr(3'd0, mk(1, 2'b11, 1, 0, 1, 1, 0, 2'd0, 0));
        wr(3'd1, 32'h300); wr(3'd2, 32'h400); wr(3'd3, 32'd3);
        clear_all;
        pulse; wait_nw(3); idle(6);
        chk(nw == 3, "R4 byte count", nw, 3);
        chk_blk("R4 byte step fixed dst", 0, 3, 32'h300, 1, 32'h400, 0);
        chk(!irq && done, "R8 irq masked", {30'h0, irq, done}, 32'h1);
    endtask

    task automatic t_swreq;
        wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 32'd2);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd1, 0));
        clear_all;
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd1, 1));
        wait_nw(2); idle(6);
        chk(nw == 2, "R2 software request", nw, 2);
        chk_blk("R4 halfword step", 0, 2, 32'h100, 2, 32'h200, 2);
    endtask

    task automatic t_pending;
        wait_n = 2;
        wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 32'd3);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        pulse; idle(4); pulse;
        wait_nw(6); idle(40);
        chk(nw == 6, "R7 held trigger one extra block", nw, 6);
        chk_blk("R7 second block reloaded", 3, 3, 32'h100, 4, 32'h200, 4);
    endtask

    task automatic t_mode;
        wait_n = 0;
        wr(3'd0, mk(1, 2'b01, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        pulse; idle(20);
        chk(nreq == 0 && !done, "R1 other mode ignored", nreq, 0);
    endtask

    task automatic t_disable;
        wait_n = 3;
        wr(3'd3, 32'd8);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        pulse; wait_nw(2);
        wr(3'd0, mk(0, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        idle(30);
        chk(nw < 8 && !mem_req && !done, "R11 disable aborts", nw, 2);
        clear_all;
        pulse; idle(20);
        chk(nreq == 0, "R11 trigger ignored when disabled", nreq, 0);
    endtask

    task automatic t_window;
        wait_n = 0;
        wr(3'd4, 32'h100); wr(3'd5, 32'h200);
        wr(3'd1, 32'h1F8); wr(3'd2, 32'h100); wr(3'd3, 32'd4);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        pulse; idle(40);
        chk(nw == 2, "R10 abort at high bound", nw, 2);
        chk(err && !chan_en && !done && !mem_req, "R10 err disables",
            {28'h0, err, chan_en, done, mem_req}, 32'h8);
        wr(3'd1, 32'h0FC);
        wr(3'd0, mk(1, 2'b11, 1, 1, 1, 1, 1, 2'd2, 0));
        clear_all;
        chk(!err, "R9 err cleared", err, 0);
        pulse; idle(20);
        chk(nreq == 0 && err, "R10 below low bound", nreq, 0);
    endtask

    task automatic t_w1c;
        wr(3'd6, 32'h0);
        idle(1);
        chk(err, "R9 write zero keeps flag", err, 1);
        wr(3'd6, 32'h4);
        idle(1);
        chk(!err, "R9 write one clears flag", err, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_basic;
        t_half;
        t_noreload;
        t_bytefixed;
        t_swreq;
        t_pending;
        t_mode;
        t_disable;
        t_window;
        t_w1c;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule